// File: doc/BRIEF.md
# Prioritised Nesting Interrupt Controller

This block sits between a set of peripheral interrupt lines and the CPU's exception sequencer. Each line has a pending flag that is set on a rising edge of the line. A per-source enable mask and a single global enable decide which of the pending sources may compete. A fixed-priority selector then picks the most urgent of them, and the block presents a registered request, the interrupt number and the handler's table address to the sequencer.

The sequencer takes a request by pulsing an acknowledge input. The block then records the accepted source on a small stack of active handlers. The top entry of that stack sets the current priority level: only a source of strictly higher priority can raise a new request, and so preempt the running handler. When the sequencer pulses return-from-handler, the top entry is popped. This clears the pending flag of the returning source and restores the level of the handler below it.

Top module: `irq_ctrl`

## Requirements
- R1: A rising edge on `irq_raw_i[s]` sets the pending flag of source s. The flag stays set until a return pops source s from the active stack. A rising edge on that source in the same cycle as the pop keeps the flag set.
- R2: A source whose bit in `irq_en_i` is 0 is never requested, even while it is pending. Setting the bit later makes a still-pending source eligible.
- R3: While `gie_i` is 0, `irq_req_o` goes to 0 at the next clock edge and stays 0. Pending flags are kept.
- R4: Among the eligible sources, the lowest index wins. `irq_num_o` equals FIRST_IRQ plus the winning index, and the reserved numbers 0 and 1 are never produced with the default FIRST_IRQ of 2.
- R5: While `irq_req_o` is 1, `irq_vec_o` equals `vec_base_i` plus 4 times `irq_num_o`.
- R6: `irq_req_o` is a register output. It reflects the state after each clock edge: a rising edge sampled at clock edge k shows as a request right after edge k.
- R7: An `ack_i` pulse while `irq_req_o` is 1 pushes the winner onto the active stack. `act_valid_o` goes to 1 and `act_num_o` shows its number. An `ack_i` pulse while `irq_req_o` is 0 is ignored.
- R8: While a handler is active, only a source with a strictly lower index than the top of the stack is requested. Sources with an equal or higher index stay pending until the handler returns. Nesting reaches a depth of NUM_SRC.
- R9: A `ret_i` pulse pops the top of the stack and restores the previous handler as active. A `ret_i` pulse with an empty stack is ignored. When `ret_i` and `ack_i` arrive in the same cycle, the return is taken and the acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_raw_i | input | NUM_SRC | Raw peripheral request lines, rising edge sensitive |
| irq_en_i | input | NUM_SRC | Per-source enable mask |
| gie_i | input | 1 | Global interrupt enable |
| vec_base_i | input | ADDR_W | Base address of the handler table |
| ack_i | input | 1 | Sequencer accepts the presented request |
| ret_i | input | 1 | Sequencer signals return from the current handler |
| irq_req_o | output | 1 | Registered interrupt request |
| irq_num_o | output | NUM_W | Interrupt number of the winning source |
| irq_vec_o | output | ADDR_W | Handler table entry address for the winner |
| act_valid_o | output | 1 | At least one handler is active |
| act_num_o | output | NUM_W | Interrupt number of the innermost active handler |

## Verification
The bench builds the block with NUM_SRC of 4 and FIRST_IRQ of 2. The small source count lets a short run fill the active stack to its full depth, with every source preempting the one below it, and then unwind it completely. With FIRST_IRQ at 2, the vector arithmetic starts at the first non-reserved table entry. A behavioural model with a queue for the active stack is compared with the outputs on every cycle. The run covers masking, global gating, simultaneous arrivals, held lower-priority requests, a return with an empty stack and a return that collides with an acknowledge.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    STK_NONE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] raw_i,
  input  logic               clr_i,
  input  logic [SRC_W-1:0]   clr_idx_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] pend_nxt_o
);
  logic [NUM_SRC-1:0] raw_q, pend_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    // an edge in the same cycle as the clear wins
    assign pend_nxt_o[g] = (pend_q[g] & ~(clr_i && clr_idx_i == SRC_W'(g)))
                         | (raw_i[g] & ~raw_q[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      pend_q <= '0;
    end else begin
      raw_q  <= raw_i;
      pend_q <= pend_nxt_o;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int unsigned LVL_W = $clog2(NUM_SRC + 1),
  localparam int unsigned CNT_W = $clog2(NUM_SRC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stk_op_e          op_i,
  input  logic [SRC_W-1:0] push_idx_i,
  output logic             valid_o,
  output logic [SRC_W-1:0] top_o,
  output logic [LVL_W-1:0] level_o,
  output logic [LVL_W-1:0] level_nxt_o
);
  logic [SRC_W-1:0] mem_q [NUM_SRC];
  logic [CNT_W-1:0] cnt_q;
  logic             full;

  assign valid_o = cnt_q != '0;
  assign full    = cnt_q == CNT_W'(NUM_SRC);
  assign top_o   = mem_q[SRC_W'(cnt_q - CNT_W'(1))];
  assign level_o = valid_o ? LVL_W'(top_o) : LVL_W'(NUM_SRC);

  always_comb begin
    unique case (op_i)
      STK_PUSH: level_nxt_o = LVL_W'(push_idx_i);
      STK_POP:  level_nxt_o = (cnt_q > CNT_W'(1))
                              ? LVL_W'(mem_q[SRC_W'(cnt_q - CNT_W'(2))])
                              : LVL_W'(NUM_SRC);
      default:  level_nxt_o = level_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < NUM_SRC; i++) mem_q[i] <= '0;
    end else begin
      unique case (op_i)
        STK_PUSH: begin
          mem_q[SRC_W'(cnt_q)] <= push_idx_i;
          cnt_q <= cnt_q + CNT_W'(1);
        end
        STK_POP:  cnt_q <= cnt_q - CNT_W'(1);
        default:  ;
      endcase
    end
  end

  // strictly rising priorities bound the depth to NUM_SRC
  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == STK_PUSH) |-> !full);
  assert_pop_nonempty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == STK_POP) |-> valid_o);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int unsigned LVL_W = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               gie_i,
  input  logic [LVL_W-1:0]   level_i,
  output logic               hit_o,
  output logic [SRC_W-1:0]   idx_o
);
  logic [NUM_SRC-1:0] elig;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign elig[g] = gie_i & en_i[g] & pend_i[g] & (LVL_W'(g) < level_i);
  end

  always_comb begin
    hit_o = |elig;
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) idx_o = SRC_W'(i);
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 8,
  parameter int unsigned FIRST_IRQ = 2,
  parameter int unsigned ADDR_W    = 32,
  localparam int unsigned SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int unsigned LVL_W = $clog2(NUM_SRC + 1),
  localparam int unsigned NUM_W = $clog2(FIRST_IRQ + NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_raw_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  input  logic               gie_i,
  input  logic [ADDR_W-1:0]  vec_base_i,
  input  logic               ack_i,
  input  logic               ret_i,
  output logic               irq_req_o,
  output logic [NUM_W-1:0]   irq_num_o,
  output logic [ADDR_W-1:0]  irq_vec_o,
  output logic               act_valid_o,
  output logic [NUM_W-1:0]   act_num_o
);
  logic [NUM_SRC-1:0] pend_q, pend_nxt;
  logic [SRC_W-1:0]   top_idx, pick_idx, win_q;
  logic [LVL_W-1:0]   level_cur, level_nxt;
  logic               ret_fire, ack_fire, pick_hit, req_q;
  stk_op_e            stk_op;

  assign ret_fire = ret_i & act_valid_o;
  assign ack_fire = ack_i & ~ret_fire & req_q;
  assign stk_op   = ret_fire ? STK_POP : (ack_fire ? STK_PUSH : STK_NONE);

  irq_pending #(.NUM_SRC(NUM_SRC)) u_pending (
    .clk_i, .rst_ni,
    .raw_i      (irq_raw_i),
    .clr_i      (ret_fire),
    .clr_idx_i  (top_idx),
    .pend_o     (pend_q),
    .pend_nxt_o (pend_nxt)
  );

  irq_nest_stack #(.NUM_SRC(NUM_SRC)) u_stack (
    .clk_i, .rst_ni,
    .op_i        (stk_op),
    .push_idx_i  (win_q),
    .valid_o     (act_valid_o),
    .top_o       (top_idx),
    .level_o     (level_cur),
    .level_nxt_o (level_nxt)
  );

  // arbitrate on next-cycle state so an accepted request drops at once
  irq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .pend_i  (pend_nxt),
    .en_i    (irq_en_i),
    .gie_i   (gie_i),
    .level_i (level_nxt),
    .hit_o   (pick_hit),
    .idx_o   (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      win_q <= '0;
    end else begin
      req_q <= pick_hit;
      if (pick_hit) win_q <= pick_idx;
    end
  end

  assign irq_req_o = req_q;
  assign irq_num_o = NUM_W'(FIRST_IRQ) + NUM_W'(win_q);
  assign irq_vec_o = vec_base_i + (ADDR_W'(irq_num_o) << 2);
  assign act_num_o = NUM_W'(FIRST_IRQ) + NUM_W'(top_idx);

  logic [NUM_SRC-1:0] win_oh;
  assign win_oh = NUM_SRC'(1) << win_q;

  assert_req_pending_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> |(pend_q & win_oh));
  assert_req_enabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> |($past(irq_en_i) & win_oh));
  assert_gie_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> $past(gie_i));
  assert_preempt_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (LVL_W'(win_q) < level_cur));
endmodule

// File: tb/irq_ctrl_tb_top.sv
module irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 4;
  localparam int FIRST = 2;
  localparam int AW    = 32;
  localparam int NW    = $clog2(FIRST + N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]  raw = '0, en = '0;
  logic          gie = 1'b0, ack = 1'b0, ret = 1'b0;
  logic [AW-1:0] base = 32'h0000_0100;
  logic          req, act_valid;
  logic [NW-1:0] num, act_num;
  logic [AW-1:0] vec;

  int vectors = 0, errors = 0;
  bit done = 0;
  string phase = "R6";

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl #(.NUM_SRC(N), .FIRST_IRQ(FIRST), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_raw_i(raw), .irq_en_i(en), .gie_i(gie),
    .vec_base_i(base), .ack_i(ack), .ret_i(ret), .irq_req_o(req),
    .irq_num_o(num), .irq_vec_o(vec), .act_valid_o(act_valid), .act_num_o(act_num)
  );

  // behavioural reference
  bit [N-1:0] m_raw, m_pend;
  bit         m_req;
  int         m_win;
  int         stk[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_raw = '0; m_pend = '0; m_req = 0; m_win = 0; stk.delete();
    end else begin
      bit rf, af;
      bit [N-1:0] pn;
      int lvl;
      rf = ret && stk.size() > 0;
      af = ack && !rf && m_req;
      pn = m_pend;
      if (rf) pn[stk[$]] = 1'b0;
      pn |= raw & ~m_raw;
      m_raw = raw;
      if (rf) void'(stk.pop_back());
      else if (af) stk.push_back(m_win);
      lvl = (stk.size() > 0) ? stk[$] : N;
      m_req = 0;
      for (int s = N - 1; s >= 0; s--)
        if (gie && en[s] && pn[s] && s < lvl) begin m_req = 1; m_win = s; end
      m_pend = pn;
    end
  end

  task automatic check(string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("req", req, m_req);
      check("act_valid", act_valid, stk.size() > 0);
      if (stk.size() > 0) check("act_num", act_num, FIRST + stk[$]);
      if (m_req) begin
        check("num", num, FIRST + m_win);
        check("vec", vec, base + 4 * (FIRST + m_win));
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic pulse_raw(int s);
    raw[s] = 1'b1; cyc(1); raw[s] = 1'b0; cyc(1);
  endtask
  task automatic do_ack();
    ack = 1'b1; cyc(1); ack = 1'b0; cyc(1);
  endtask
  task automatic do_ret();
    ret = 1'b1; cyc(1); ret = 1'b0; cyc(1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    // reset state, R6
    #1;
    vectors++;
    if (req !== 1'b0 || act_valid !== 1'b0) begin
      errors++;
      $display("FAIL R6 reset: actual req=%b act=%b expected 0 0", req, act_valid);
    end
    cyc(1);
    gie = 1'b1; en = '1;
    phase = "R1 R6 R4"; pulse_raw(2); cyc(2);
    phase = "R5"; base = 32'h1000_0000; cyc(2);
    phase = "R7"; do_ack(); cyc(2);
    phase = "R7 no-req ack"; do_ack(); cyc(1);
    phase = "R8 held"; pulse_raw(3); pulse_raw(2); cyc(3);
    phase = "R8 preempt"; pulse_raw(1); do_ack(); cyc(2);
    phase = "R9"; do_ret(); cyc(2); do_ret(); cyc(2);
    phase = "R9 R1"; do_ack(); do_ret(); cyc(2);
    phase = "R9 empty ret"; do_ret(); cyc(2);
    phase = "R2"; en = 4'b1110; pulse_raw(0); cyc(3); en = '1; cyc(2);
    phase = "R3"; gie = 1'b0; cyc(3); pulse_raw(3); cyc(2); gie = 1'b1; cyc(2);
    phase = "R4"; do_ack(); do_ret(); do_ret(); cyc(1);
    raw = 4'b1110; cyc(1); raw = '0; cyc(2);
    do_ack(); do_ack(); do_ack(); cyc(1);
    do_ret(); do_ret(); do_ret(); cyc(2);
    phase = "R8 depth"; en = 4'b1000; raw = '1; cyc(1); raw = '0; cyc(1);
    do_ack(); en = 4'b1100; cyc(1); do_ack(); en = 4'b1110; cyc(1); do_ack();
    en = 4'b1111; cyc(1); do_ack(); cyc(2);
    phase = "R9 unwind"; do_ret(); do_ret(); do_ret(); do_ret(); do_ret(); cyc(2);
    phase = "R9 ret+ack"; pulse_raw(2); do_ack(); pulse_raw(1);
    ack = 1'b1; ret = 1'b1; cyc(1); ack = 1'b0; ret = 1'b0; cyc(2);
    do_ack(); do_ret(); do_ret(); cyc(2);
    phase = "R1 clear edge"; pulse_raw(3); do_ack();
    raw[3] = 1'b1; ret = 1'b1; cyc(1); ret = 1'b0; raw[3] = 1'b0; cyc(3);
    do_ack(); do_ret(); cyc(3);
    finish_run();
  end
endmodule